// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the pixel cadence and synchronisation strobes for a TFT raster panel. A single reference clock is divided by a programmable ratio into a one-cycle pixel enable and a square pixel clock. Two cascaded position counters walk through the horizontal and vertical segments of a frame: sync, back porch, active area and front porch. From those counters the block derives horizontal and vertical sync, a data-enable flag and the pixel and line coordinates inside the active area.

Configuration arrives as four 32-bit words: a control word holding the divisor and three timing words. In these words the horizontal porch and sync lengths are stored minus one and split into low and high bit groups. The vertical porches are stored as plain line counts, and the active width is coded in steps of sixteen pixels. While the enable input is low, the block tracks the words continuously. While it runs, it takes new words only at frame boundaries, so software may rewrite them at any time without tearing a frame. The pixel data path, palettes and panel bias waveforms belong to neighbouring blocks. Those blocks consume `pix_ce`, `de` and the coordinates.

All pins are plain control or status pins. No stream handshake is involved, because the generator is a free-running source paced only by its divisor.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_ce` is high for exactly one clock out of every DIV clocks, where DIV is `ctrl_word[15:8]`. After enable rises with legal words, the first pulse occurs when DIV-1 rising edges have passed. `pclk_out` (before inversion) is high during the first floor(DIV/2) clocks of each DIV-clock period and low for the rest, and each period starts on the clock after a `pix_ce` pulse.
- R2: A configuration is illegal when DIV < 2 or any reserved bit is set. The reserved bits are `ctrl_word` bits 31:16 and 7:0, `timing0` bits 2:0, and `timing2` bits 31, 23, 19:6 and 3:2. With illegal words loaded, `pix_ce` and `de` stay low and the raw syncs stay inactive. `sync_lost` goes high for exactly one cycle, on the first cycle after the enable rise (or one cycle after a frame boundary that loaded the illegal words).
- R3: Horizontal sync, back porch and front porch lengths are each the field value plus one, with 10-bit fields. Back porch bits 7:0 are in `timing0[31:24]` and bits 9:8 are in `timing2[5:4]`. Front porch bits 7:0 are in `timing0[23:16]` and bits 9:8 are in `timing2[1:0]`. Sync bits 5:0 are in `timing0[15:10]` and bits 9:6 are in `timing2[30:27]`.
- R4: The active width minus one has bits 9:4 in `timing0[9:4]` and bit 10 in `timing0[3]`. Its low four bits are implied as ones, so the width is a multiple of 16, up to 2048.
- R5: Vertical back and front porch are plain line counts (zero allowed) in `timing1[31:24]` and `timing1[23:16]`. Vertical sync is the value of `timing1[15:10]` plus one. The active line count minus one has bits 9:0 in `timing1[9:0]` and bit 10 in `timing2[26]`.
- R6: Each line runs sync, back porch, active, front porch in pixel-clock steps, and each frame runs the same four segments in lines. `de` is high only when both axes are in their active segments. While `de` is high, `pix_x` and `line_y` give the zero-based position inside the active area; while it is low, both are 0.
- R7: `timing2[21]` inverts `hsync`, `timing2[20]` inverts `vsync` and `timing2[22]` inverts `pclk_out`. With the bit clear, the output is active high.
- R8: When `timing2[25]` is 1 and `timing2[24]` is 0, `hsync` and `vsync` change on the clock where `pclk_out` falls. They take the raw value that was valid in the cycle before, and they read inactive until the first such edge. Otherwise they change together with the counters, on the pixel clock's rising edge.
- R9: `frame_done` is high for exactly one cycle: the cycle after the `pix_ce` that ends the last pixel of the last front-porch line.
- R10: Clearing `enable` stops `pix_ce` and `de` at once, and one clock later the counters are back at frame start. While enabled, words changed mid-frame take effect only after the frame boundary.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low clears the counters |
| ctrl_word | input | 32 | Control word, divisor in bits 15:8 |
| timing0 | input | 32 | Horizontal timing word |
| timing1 | input | 32 | Vertical timing word |
| timing2 | input | 32 | High bits, polarity and sync-edge controls |
| pix_ce | output | 1 | One-cycle pixel clock enable |
| pclk_out | output | 1 | Pixel clock level, polarity applied |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Active-area data enable |
| pix_x | output | COORD_W | Pixel index in the active line |
| line_y | output | COORD_W | Line index in the active area |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| sync_lost | output | 1 | One-cycle pulse on loading an illegal configuration |

## Verification
The bench builds the generator with its default parameters: 13-bit segment counters and 11-bit coordinates. These are wide enough that a 1040-pixel line with 300-pixel back porch and 70-pixel sync exercises every split high-bit group. A 1025-line frame drives the line-count bit held in the third timing word, and the bench watches only its first lines. Small random geometries with divisors of 2 to 5 let whole frames run many times, which reaches frame wrap, zero-length vertical porches and both sync-edge modes.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int SPAN_W = 13;
  localparam int DIV_W  = 8;
  localparam int N_SEG  = 4;

  typedef logic [SPAN_W-1:0] span_t;

  typedef enum logic [1:0] {
    SEG_SYNC   = 2'd0,
    SEG_BACK   = 2'd1,
    SEG_ACTIVE = 2'd2,
    SEG_FRONT  = 2'd3
  } seg_e;

  // Segment lengths are indexed in sequence order: sync, back, active, front.
  typedef struct packed {
    logic [DIV_W-1:0]        div;
    logic [N_SEG-1:0][SPAN_W-1:0] h_len;
    logic [N_SEG-1:0][SPAN_W-1:0] v_len;
    logic                    inv_h;
    logic                    inv_v;
    logic                    inv_pc;
    logic                    sync_fall;
    logic                    illegal;
  } raster_cfg_t;

endpackage

// File: rtl/raster_cfg_decode.sv
module raster_cfg_decode
  import raster_pkg::*;
(
  input  logic [31:0] ctrl_w,
  input  logic [31:0] t0_w,
  input  logic [31:0] t1_w,
  input  logic [31:0] t2_w,
  output raster_cfg_t cfg
);

  logic [9:0]  hsw_m1;
  logic [9:0]  hbp_m1;
  logic [9:0]  hfp_m1;
  logic [10:0] wid_m1;
  logic [10:0] lpp_m1;
  logic [5:0]  vsw_m1;
  logic        rsvd_set;

  always_comb begin
    // Gather split fields back into contiguous values.
    hsw_m1 = {t2_w[30:27], t0_w[15:10]};
    hbp_m1 = {t2_w[5:4],   t0_w[31:24]};
    hfp_m1 = {t2_w[1:0],   t0_w[23:16]};
    wid_m1 = {t0_w[3], t0_w[9:4], 4'hF};
    lpp_m1 = {t2_w[26], t1_w[9:0]};
    vsw_m1 = t1_w[15:10];

    rsvd_set = (|ctrl_w[31:16]) | (|ctrl_w[7:0]) | (|t0_w[2:0]) |
               t2_w[31] | t2_w[23] | (|t2_w[19:6]) | (|t2_w[3:2]);

    cfg          = '0;
    cfg.div      = ctrl_w[15:8];
    cfg.h_len[0] = span_t'(hsw_m1) + span_t'(1);
    cfg.h_len[1] = span_t'(hbp_m1) + span_t'(1);
    cfg.h_len[2] = span_t'(wid_m1) + span_t'(1);
    cfg.h_len[3] = span_t'(hfp_m1) + span_t'(1);
    cfg.v_len[0] = span_t'(vsw_m1) + span_t'(1);
    cfg.v_len[1] = span_t'(t1_w[31:24]);
    cfg.v_len[2] = span_t'(lpp_m1) + span_t'(1);
    cfg.v_len[3] = span_t'(t1_w[23:16]);
    cfg.inv_pc   = t2_w[22];
    cfg.inv_h    = t2_w[21];
    cfg.inv_v    = t2_w[20];
    cfg.sync_fall = t2_w[25] & ~t2_w[24];
    cfg.illegal  = (ctrl_w[15:8] < 8'd2) | rsvd_set;
  end

endmodule

// File: rtl/raster_pclk_gen.sv
module raster_pclk_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          rise_ce,
  output logic          fall_ce,
  output logic          level
);

  logic [DW-1:0] phase;
  logic [DW-1:0] half;

  assign half = div >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n)                        phase <= '0;
    else if (!run)                     phase <= '0;
    else if (phase == div - DW'(1))    phase <= '0;
    else                               phase <= phase + DW'(1);
  end

  // Rising pixel edge closes a period; falling edge sits at its midpoint.
  assign rise_ce = run && (phase == div - DW'(1));
  assign fall_ce = run && (phase == half - DW'(1));
  assign level   = run && (phase < half);

endmodule

// File: rtl/raster_axis_ctr.sv
module raster_axis_ctr
  import raster_pkg::*;
#(
  parameter int CW   = SPAN_W,
  parameter int NSEG = N_SEG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic [NSEG-1:0][CW-1:0]  len,
  output seg_e                     seg,
  output logic                     last,
  output logic [CW-1:0]            act_idx
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] bound [NSEG+1];

  assign bound[0] = '0;
  for (genvar g = 0; g < NSEG; g++) begin : g_bound
    assign bound[g+1] = bound[g] + len[g];
  end

  assign last = (cnt == bound[NSEG] - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (step)  cnt <= last ? '0 : cnt + CW'(1);
  end

  always_comb begin
    if (cnt < bound[1])      seg = SEG_SYNC;
    else if (cnt < bound[2]) seg = SEG_BACK;
    else if (cnt < bound[3]) seg = SEG_ACTIVE;
    else                     seg = SEG_FRONT;
    act_idx = (seg == SEG_ACTIVE) ? cnt - bound[2] : '0;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [31:0]        ctrl_word,
  input  logic [31:0]        timing0,
  input  logic [31:0]        timing1,
  input  logic [31:0]        timing2,
  output logic               pix_ce,
  output logic               pclk_out,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] line_y,
  output logic               frame_done,
  output logic               sync_lost
);

  localparam int CW = SPAN_W;

  logic [31:0] ctrl_q, t0_q, t1_q, t2_q;
  raster_cfg_t cfg;
  logic running, rise_ce, fall_ce, pclk_lvl;
  logic en_q, fd_q, lost_q, hs_f, vs_f;
  logic h_last, v_last, frame_end;
  seg_e h_seg, v_seg;
  logic [CW-1:0] h_idx, v_idx;
  logic hs_raw, vs_raw, de_raw;

  // Shadow words: follow the inputs while idle, refresh at frame boundaries.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      t0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
    end else if (!enable || frame_end) begin
      ctrl_q <= ctrl_word;
      t0_q   <= timing0;
      t1_q   <= timing1;
      t2_q   <= timing2;
    end
  end

  raster_cfg_decode u_dec (
    .ctrl_w (ctrl_q),
    .t0_w   (t0_q),
    .t1_w   (t1_q),
    .t2_w   (t2_q),
    .cfg    (cfg)
  );

  assign running = enable && !cfg.illegal;

  raster_pclk_gen #(.DW(DIV_W)) u_pclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .div     (cfg.div),
    .rise_ce (rise_ce),
    .fall_ce (fall_ce),
    .level   (pclk_lvl)
  );

  raster_axis_ctr #(.CW(CW)) u_hctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!running),
    .step    (rise_ce),
    .len     (cfg.h_len),
    .seg     (h_seg),
    .last    (h_last),
    .act_idx (h_idx)
  );

  raster_axis_ctr #(.CW(CW)) u_vctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!running),
    .step    (rise_ce && h_last),
    .len     (cfg.v_len),
    .seg     (v_seg),
    .last    (v_last),
    .act_idx (v_idx)
  );

  assign frame_end = rise_ce && h_last && v_last;

  assign hs_raw = running && (h_seg == SEG_SYNC);
  assign vs_raw = running && (v_seg == SEG_SYNC);
  assign de_raw = running && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fd_q   <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      en_q   <= enable;
      fd_q   <= frame_end;
      lost_q <= enable && cfg.illegal && (!en_q || fd_q);
    end
  end

  // Sync copies that move on the falling pixel-clock edge.
  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      hs_f <= 1'b0;
      vs_f <= 1'b0;
    end else if (fall_ce) begin
      hs_f <= hs_raw;
      vs_f <= vs_raw;
    end
  end

  assign pix_ce     = rise_ce;
  assign pclk_out   = pclk_lvl ^ cfg.inv_pc;
  assign hsync      = (cfg.sync_fall ? hs_f : hs_raw) ^ cfg.inv_h;
  assign vsync      = (cfg.sync_fall ? vs_f : vs_raw) ^ cfg.inv_v;
  assign de         = de_raw;
  assign pix_x      = de_raw ? COORD_W'(h_idx) : '0;
  assign line_y     = de_raw ? COORD_W'(v_idx) : '0;
  assign frame_done = fd_q;
  assign sync_lost  = lost_q;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic pix_ce,
  input logic de,
  input logic frame_done,
  input logic sync_lost
);

  // R1: divisor of at least two keeps pixel enables apart
  assert_ce_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  // R2: an illegal load never produces a pixel enable
  assert_lost_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !pix_ce);

  // R6: data enable only moves on a pixel tick while running
  assert_de_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(de)) |-> $past(pix_ce));

  // R9: end-of-frame strobe lasts one cycle
  assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: disabled generator is quiet on the next cycle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pix_ce && !de));

endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .pix_ce     (pix_ce),
  .de         (de),
  .frame_done (frame_done),
  .sync_lost  (sync_lost)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n, enable;
  logic [31:0] ctrl_word, timing0, timing1, timing2;
  logic        pix_ce, pclk_out, hsync, vsync, de, frame_done, sync_lost;
  logic [10:0] pix_x, line_y;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .timing0(timing0), .timing1(timing1), .timing2(timing2),
    .pix_ce(pix_ce), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .line_y(line_y),
    .frame_done(frame_done), .sync_lost(sync_lost)
  );

  typedef struct {
    int div, hsw, hbp, wid, hfp, vsw, vbp, lines, vfp;
    bit ihs, ivs, ipc, sctl, sedge;
  } tcfg_t;

  function automatic logic [31:0] enc_ctrl(tcfg_t c);
    return {16'h0, 8'(c.div), 8'h0};
  endfunction

  function automatic logic [31:0] enc_t0(tcfg_t c);
    logic [9:0] hbp = 10'(c.hbp - 1), hfp = 10'(c.hfp - 1), hsw = 10'(c.hsw - 1);
    logic [10:0] w = 11'(c.wid - 1);
    return {hbp[7:0], hfp[7:0], hsw[5:0], w[9:4], w[10], 3'b0};
  endfunction

  function automatic logic [31:0] enc_t1(tcfg_t c);
    logic [10:0] l = 11'(c.lines - 1);
    return {8'(c.vbp), 8'(c.vfp), 6'(c.vsw - 1), l[9:0]};
  endfunction

  function automatic logic [31:0] enc_t2(tcfg_t c, bit ihs);
    logic [9:0] hbp = 10'(c.hbp - 1), hfp = 10'(c.hfp - 1), hsw = 10'(c.hsw - 1);
    logic [10:0] l = 11'(c.lines - 1);
    return {1'b0, hsw[9:6], l[10], c.sctl, c.sedge, 1'b0, c.ipc, ihs, c.ivs,
            14'h0, hbp[9:8], 2'b00, hfp[9:8]};
  endfunction

  function automatic int htot(tcfg_t c); return c.hsw + c.hbp + c.wid + c.hfp; endfunction
  function automatic int vtot(tcfg_t c); return c.vsw + c.vbp + c.lines + c.vfp; endfunction

  function automatic void raw_at(tcfg_t c, int cnt, output bit hs, output bit vs,
                                 output bit d, output int x, output int y);
    int h = cnt % htot(c);
    int v = (cnt / htot(c)) % vtot(c);
    bit ha = (h >= c.hsw + c.hbp) && (h < c.hsw + c.hbp + c.wid);
    bit va = (v >= c.vsw + c.vbp) && (v < c.vsw + c.vbp + c.lines);
    hs = (h < c.hsw);
    vs = (v < c.vsw);
    d  = ha && va;
    x  = d ? h - c.hsw - c.hbp : 0;
    y  = d ? v - c.vsw - c.vbp : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // k = rising edges since enable rose with legal words
  task automatic expect_at(tcfg_t c, int k, bit ihs_eff, string req);
    int fpix = htot(c) * vtot(c);
    int h2 = c.div / 2;
    bit hs, vs, d, fhs, fvs;
    int x, y, fx, fy;
    bit fall_mode = c.sctl && !c.sedge;
    raw_at(c, k / c.div, hs, vs, d, x, y);
    fhs = 0; fvs = 0;
    if (k >= h2) begin
      int xe = (k - 1) - (((k - 1) - (h2 - 1)) % c.div);
      bit fd;
      raw_at(c, xe / c.div, fhs, fvs, fd, fx, fy);
    end
    chk({req, " R1"}, "pix_ce", int'(pix_ce), int'((k % c.div) == c.div - 1));
    chk({req, " R7"}, "pclk_out", int'(pclk_out), int'(((k % c.div) < h2) ^ c.ipc));
    chk({req, " R8"}, "hsync", int'(hsync), int'((fall_mode ? fhs : hs) ^ ihs_eff));
    chk({req, " R8"}, "vsync", int'(vsync), int'((fall_mode ? fvs : vs) ^ c.ivs));
    chk({req, " R6"}, "de", int'(de), int'(d));
    chk({req, " R6"}, "pix_x", int'(pix_x), x);
    chk({req, " R6"}, "line_y", int'(line_y), y);
    chk({req, " R9"}, "frame_done", int'(frame_done),
        int'(k > 0 && (k % c.div) == 0 && ((k / c.div) % fpix) == 0));
    chk({req, " R2"}, "sync_lost", int'(sync_lost), 0);
  endtask

  task automatic load_words(tcfg_t c);
    @(negedge clk);
    enable    = 1'b0;
    ctrl_word = enc_ctrl(c);
    timing0   = enc_t0(c);
    timing1   = enc_t1(c);
    timing2   = enc_t2(c, c.ihs);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cfg(tcfg_t c, int ncyc, int flip_at, string req);
    int flip_k = htot(c) * vtot(c) * c.div;
    load_words(c);
    enable = 1'b1;
    #1;
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      expect_at(c, k, c.ihs ^ (flip_at >= 0 && k >= flip_k), req);
      if (k == flip_at) timing2 = enc_t2(c, !c.ihs);   // R10 mid-frame rewrite
    end
  endtask

  function automatic tcfg_t mk(int div, int hsw, int hbp, int wid, int hfp,
                               int vsw, int vbp, int lines, int vfp,
                               bit ihs, bit ivs, bit ipc, bit sctl, bit sedge);
    tcfg_t c;
    c.div = div; c.hsw = hsw; c.hbp = hbp; c.wid = wid; c.hfp = hfp;
    c.vsw = vsw; c.vbp = vbp; c.lines = lines; c.vfp = vfp;
    c.ihs = ihs; c.ivs = ivs; c.ipc = ipc; c.sctl = sctl; c.sedge = sedge;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tcfg_t c;
    void'($urandom(32'd2024));
    rst_n = 1'b0; enable = 1'b0;
    ctrl_word = '0; timing0 = '0; timing1 = '0; timing2 = '0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk("R11", "pix_ce", int'(pix_ce), 0);
    chk("R11", "pclk_out", int'(pclk_out), 0);
    chk("R11", "hsync", int'(hsync), 0);
    chk("R11", "vsync", int'(vsync), 0);
    chk("R11", "de", int'(de), 0);
    chk("R11", "frame_done", int'(frame_done), 0);
    chk("R11", "sync_lost", int'(sync_lost), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Smallest geometry, zero vertical porches, two frames
    c = mk(2, 1, 1, 16, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    run_cfg(c, 2 * 19 * 2 * 2 + 6, -1, "min R5 R9");

    // Falling-edge sync mode with inversions
    c = mk(4, 2, 3, 16, 2, 2, 1, 2, 1, 1, 1, 1, 1, 0);
    run_cfg(c, htot(c) * vtot(c) * 4 + 20, -1, "fall R8 R7");

    // Wide horizontal fields: every split high bit group in use
    c = mk(2, 70, 300, 1040, 260, 1, 0, 1, 0, 0, 1, 0, 1, 1);
    run_cfg(c, htot(c) * 2 * 2 + 4, -1, "wide R3 R4");

    // Line count needing the high bit stored in the third word
    c = mk(3, 1, 1, 16, 1, 1, 0, 1025, 0, 0, 0, 0, 0, 0);
    run_cfg(c, 19 * 7 * 3, -1, "tall R5");

    // Mid-frame rewrite of hsync polarity applies at the boundary
    c = mk(2, 2, 2, 16, 2, 1, 1, 2, 1, 0, 0, 0, 0, 0);
    run_cfg(c, htot(c) * vtot(c) * 2 * 2, htot(c) * vtot(c), "shadow R10");

    // Clear enable mid-run: quiet at once, home position after one edge
    enable = 1'b0;
    #1;
    chk("R10", "pix_ce", int'(pix_ce), 0);
    chk("R10", "de", int'(de), 0);
    @(negedge clk); #1;
    chk("R10", "pix_x", int'(pix_x), 0);
    chk("R10", "line_y", int'(line_y), 0);
    chk("R10", "hsync", int'(hsync), int'(!c.ihs));

    // Illegal divisor then a reserved bit: stall and one sync_lost pulse
    for (int t = 0; t < 2; t++) begin
      c = mk(t == 0 ? 1 : 3, 2, 2, 16, 2, 1, 1, 1, 1, 1, 0, 1, 0, 0);
      load_words(c);
      if (t == 1) begin
        ctrl_word[0] = 1'b1;
        @(negedge clk);
      end
      enable = 1'b1;
      #1;
      for (int k = 0; k < 12; k++) begin
        if (k > 0) begin @(negedge clk); #1; end
        chk("R2", "sync_lost", int'(sync_lost), int'(k == 1));
        chk("R2", "pix_ce", int'(pix_ce), 0);
        chk("R2", "de", int'(de), 0);
        chk("R2", "hsync", int'(hsync), int'(c.ihs));
        chk("R2", "pclk_out", int'(pclk_out), int'(c.ipc));
      end
    end

    // Constrained random geometries, two frames each
    for (int r = 0; r < 10; r++) begin
      c = mk($urandom_range(5, 2), $urandom_range(4, 1), $urandom_range(4, 1),
             16 * $urandom_range(2, 1), $urandom_range(3, 1),
             $urandom_range(3, 1), $urandom_range(2, 0), $urandom_range(4, 1),
             $urandom_range(2, 0), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
             1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      run_cfg(c, htot(c) * vtot(c) * c.div * 2 + 5, -1, "rand R3 R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule